// File: doc/BRIEF.md
# Stopwatch Direction and Pause Controller

This block is a Moore state machine that steers an up-down time counter from three debounced push-button levels. It produces two control levels. The first, `countup_o`, selects whether the counter increments (1) or decrements (0). The second, `paused_o`, freezes the counter (1) or lets it run (0). The up button selects counting up and the down button selects counting down. The center button toggles between running and frozen.

A center button that is held for many cycles must toggle the pause state only once. The machine therefore passes through a wait state after each center press. It leaves that state only once center has gone back to 0. The wait state already shows the new pause level, so a toggle takes effect on the clock edge that samples the press. The counting direction is held alongside the mode, which means a pause and resume cycle never loses it. Both outputs are decoded from the state register alone.

The button inputs are expected to be debounced and synchronous to `clk_i`. They are normally one-hot or all zero. The counter and the display are outside this block.

Top module: `stopwatch_ctrl`

## Requirements
- R1: While `rst_ni` is 0, and after it is released until the first button press, `countup_o` = 1 and `paused_o` = 0. Reset is asynchronous.
- R2: In a settled (non-wait) state with center at 0, an edge sampling up = 1 sets `countup_o` to 1. An edge sampling down = 1 with up at 0 sets `countup_o` to 0. Neither press changes `paused_o`.
- R3: In a running settled state, an edge sampling center = 1 sets `paused_o` to 1 at that edge and leaves `countup_o` unchanged.
- R4: While center stays 1 after a toggle, both outputs hold their values on every edge, so a held button never toggles pause a second time.
- R5: In a frozen settled state, an edge sampling center = 1 sets `paused_o` to 0 at that edge. After center is released, the pause level stays as it is until the next center press.
- R6: The counting direction in force before a pause is still in force after the machine resumes.
- R7: While frozen, up and down presses change `countup_o` and leave `paused_o` at 1. More generally, `paused_o` never changes on an edge that samples center = 0.
- R8: In a wait state, up and down are ignored. On the edge where center is seen at 0, the machine enters the settled state, and an up or down pulse sampled on that same edge does not change `countup_o`.
- R9: If center is 1 together with up or down in a settled state, center takes priority. Pause toggles and `countup_o` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Debounced up button level, 1 while pressed |
| center_i | input | 1 | Debounced center button level, 1 while pressed |
| down_i | input | 1 | Debounced down button level, 1 while pressed |
| countup_o | output | 1 | 1: counter increments, 0: counter decrements |
| paused_o | output | 1 | 1: counter frozen, 0: counter running |

## Verification
The bench alternates single-cycle direction presses with long center holds of four to five cycles.

- The long holds separate a correct single toggle from the oscillating level-triggered form.
- Direction presses made while frozen, followed by a resume, show whether direction and pause are kept apart.
- A direction pulse timed to the very edge where center is released targets the wait-state exit.
- Presses that combine center with a direction button check the priority rule.
- A reset applied mid-sequence, from the state `countup_o` = 0 and `paused_o` = 1, shows that reset reaches the defined start state from anywhere.

// File: rtl/stopwatch_ctrl_pkg.sv
package stopwatch_ctrl_pkg;

  typedef enum logic [1:0] {
    M_RUN        = 2'd0,
    M_HOLD_ENTER = 2'd1,  // frozen, waiting for center release
    M_FROZEN     = 2'd2,
    M_HOLD_EXIT  = 2'd3   // running, waiting for center release
  } sw_mode_e;

  typedef struct packed {
    sw_mode_e mode;
    logic     dir_up;
  } sw_state_t;

  typedef struct packed {
    logic toggle;
    logic go_up;
    logic go_down;
  } sw_evt_t;

  function automatic logic mode_is_wait(sw_mode_e m);
    return (m == M_HOLD_ENTER) || (m == M_HOLD_EXIT);
  endfunction

  function automatic logic mode_is_frozen(sw_mode_e m);
    return (m == M_HOLD_ENTER) || (m == M_FROZEN);
  endfunction

endpackage

// File: rtl/stopwatch_btn_events.sv
module stopwatch_btn_events
  import stopwatch_ctrl_pkg::*;
(
  input  logic    up_i,
  input  logic    center_i,
  input  logic    down_i,
  output sw_evt_t evt_o
);
  // center outranks up, up outranks down
  always_comb begin
    evt_o.toggle  = center_i;
    evt_o.go_up   = !center_i && up_i;
    evt_o.go_down = !center_i && !up_i && down_i;
  end
endmodule

// File: rtl/stopwatch_next_state.sv
module stopwatch_next_state
  import stopwatch_ctrl_pkg::*;
(
  input  sw_state_t cur_i,
  input  sw_evt_t   evt_i,
  output sw_state_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i.mode)
      M_RUN: begin
        if (evt_i.toggle)       nxt_o.mode   = M_HOLD_ENTER;
        else if (evt_i.go_up)   nxt_o.dir_up = 1'b1;
        else if (evt_i.go_down) nxt_o.dir_up = 1'b0;
      end
      M_FROZEN: begin
        if (evt_i.toggle)       nxt_o.mode   = M_HOLD_EXIT;
        else if (evt_i.go_up)   nxt_o.dir_up = 1'b1;
        else if (evt_i.go_down) nxt_o.dir_up = 1'b0;
      end
      M_HOLD_ENTER: if (!evt_i.toggle) nxt_o.mode = M_FROZEN;
      M_HOLD_EXIT:  if (!evt_i.toggle) nxt_o.mode = M_RUN;
      default:      nxt_o.mode = M_RUN;
    endcase
  end
endmodule

// File: rtl/stopwatch_out_decode.sv
module stopwatch_out_decode
  import stopwatch_ctrl_pkg::*;
(
  input  sw_state_t st_i,
  output logic      countup_o,
  output logic      paused_o,
  output logic      in_wait_o
);
  always_comb begin
    countup_o = st_i.dir_up;
    paused_o  = mode_is_frozen(st_i.mode);
    in_wait_o = mode_is_wait(st_i.mode);
  end
endmodule

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl
  import stopwatch_ctrl_pkg::*;
#(
  parameter bit RESET_DIR_UP = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic center_i,
  input  logic down_i,
  output logic countup_o,
  output logic paused_o
);
  localparam sw_state_t RESET_STATE = '{mode: M_RUN, dir_up: RESET_DIR_UP};

  sw_state_t state_q, state_d;
  sw_evt_t   evt;
  logic      in_wait;

  stopwatch_btn_events u_events (
    .up_i    (up_i),
    .center_i(center_i),
    .down_i  (down_i),
    .evt_o   (evt)
  );

  stopwatch_next_state u_next (
    .cur_i(state_q),
    .evt_i(evt),
    .nxt_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RESET_STATE;
    else         state_q <= state_d;
  end

  stopwatch_out_decode u_dec (
    .st_i     (state_q),
    .countup_o(countup_o),
    .paused_o (paused_o),
    .in_wait_o(in_wait)
  );
endmodule

// File: rtl/stopwatch_ctrl_chk.sv
module stopwatch_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic up_i,
  input logic center_i,
  input logic down_i,
  input logic countup_o,
  input logic paused_o,
  input logic in_wait_i
);
  assert_up_sets_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_wait_i && up_i && !center_i) |=> countup_o);

  assert_down_clears_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_wait_i && down_i && !up_i && !center_i) |=> !countup_o);

  assert_center_pauses_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_wait_i && center_i && !paused_o) |=> paused_o);

  assert_center_resumes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_wait_i && center_i && paused_o) |=> !paused_o);

  assert_hold_is_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait_i && center_i) |=> ($stable(paused_o) && $stable(countup_o)));

  assert_no_center_no_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !center_i |=> $stable(paused_o));

  assert_wait_keeps_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wait_i |=> $stable(countup_o));

  assert_center_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_wait_i && center_i) |=> $stable(countup_o));
endmodule

bind stopwatch_ctrl stopwatch_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .up_i     (up_i),
  .center_i (center_i),
  .down_i   (down_i),
  .countup_o(countup_o),
  .paused_o (paused_o),
  .in_wait_i(in_wait)
);

// File: tb/test_stopwatch_ctrl.sv
module test_stopwatch_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic up = 1'b0, center = 1'b0, down = 1'b0;
  logic countup, paused;

  typedef struct {
    logic  cu;
    logic  pa;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  stopwatch_ctrl i_stopwatch_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .up_i     (up),
    .center_i (center),
    .down_i   (down),
    .countup_o(countup),
    .paused_o (paused)
  );

  task automatic check_now(logic cu, logic pa, string req);
    checks++;
    if (countup !== cu || paused !== pa) begin
      errors++;
      $display("FAIL %s: countup=%b paused=%b expected countup=%b paused=%b",
               req, countup, paused, cu, pa);
    end
  endtask

  // drive one cycle of buttons and queue the outputs expected after the edge
  task automatic step(logic u, logic c, logic d, logic cu, logic pa, string req);
    exp_t e;
    @(negedge clk);
    up = u; center = c; down = d;
    e.cu = cu; e.pa = pa; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: compare one queued item per edge
  always @(posedge clk) begin
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_now(e.cu, e.pa, e.req);
    end
  end

  initial begin
    #40;
    check_now(1'b1, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0,0,0, 1,0, "R1 idle after reset");
    step(0,0,0, 1,0, "R1 idle after reset");
    step(0,0,1, 0,0, "R2 down");
    step(0,0,0, 0,0, "R2 hold");
    step(1,0,0, 1,0, "R2 up");
    step(0,0,1, 0,0, "R2 down again");
    step(0,1,0, 0,1, "R3 center pauses");
    for (int i = 0; i < 5; i++) step(0,1,0, 0,1, "R4 held center");
    step(0,0,0, 0,1, "R5 release keeps pause");
    step(0,0,0, 0,1, "R5 idle frozen");
    step(1,0,0, 1,1, "R7 up while frozen");
    step(0,0,1, 0,1, "R7 down while frozen");
    step(0,1,0, 0,0, "R5 center resumes");
    for (int i = 0; i < 4; i++) step(0,1,0, 0,0, "R4 held center resume");
    step(0,0,0, 0,0, "R6 direction kept");
    step(1,0,0, 1,0, "R2 up running");
    step(0,1,0, 1,1, "R3 pause up");
    step(0,1,0, 1,1, "R4 held");
    step(0,0,1, 1,1, "R8 down at release ignored");
    step(0,0,0, 1,1, "R8 settled frozen");
    step(0,1,0, 1,0, "R5 resume");
    step(1,0,0, 1,0, "R8 up at release");
    step(0,0,0, 1,0, "R6 running up");
    step(0,1,1, 1,1, "R9 center over down");
    step(0,0,0, 1,1, "R9 settled");
    step(0,1,1, 1,0, "R9 center over down frozen");
    step(0,0,0, 1,0, "R9 settled running");
    step(0,0,1, 0,0, "R2 down");
    step(0,1,0, 0,1, "R3 pause down");
    step(0,0,0, 0,1, "R5 frozen down");
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check_now(1'b1, 1'b0, "R1 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0,0,0, 1,0, "R1 after mid reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule